// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Codec

This block carries an N-bit word across a channel that has no request wire. Each data bit travels on a pair of wires: one wire stands for a zero and the other for a one. The receiver decides from the wires alone that a whole word has arrived, so the timing of the wire pairs relative to each other does not matter. The block has two independent halves that share one clock. The sender takes a single-rail word with a valid strobe and puts it on the wire pairs. The receiver watches the pairs, finds that the word is complete, delivers it as a single-rail word and answers with an acknowledge.

By default the channel runs a return-to-zero protocol. The sender drives a codeword and holds it until acknowledge rises. It then drives the spacer, with every wire low, until acknowledge falls, and only then takes the next word. The receiver raises acknowledge once every pair carries exactly one high wire. It lowers acknowledge once every wire is low again. When the parameter `TWO_PHASE` is set, the channel carries values as transitions instead. For each bit, exactly one wire of the pair toggles: the one-wire for a 1 and the zero-wire for a 0. No spacer is sent, and each toggle of acknowledge completes one word. A pair with both wires high (levels) or both wires toggled (transitions) is an illegal code and is reported on an error output.

Sender states: `TX_IDLE` (ready for a word), `TX_SEND` (codeword on the wires, waiting for acknowledge), `TX_RTZ` (spacer on the wires, waiting for acknowledge to drop; return-to-zero mode only). Sender transitions: `TX_IDLE`→`TX_SEND` on an accepted word. `TX_SEND`→`TX_RTZ` on acknowledge high (return-to-zero mode). `TX_SEND`→`TX_IDLE` on acknowledge reaching the new phase (transition mode). `TX_RTZ`→`TX_IDLE` on acknowledge low. Receiver states: `RX_WAIT_WORD` (acknowledge low, watching for completion) and `RX_WAIT_SPACER` (acknowledge high, watching for all-low; return-to-zero mode only). Receiver transitions: `RX_WAIT_WORD`→`RX_WAIT_SPACER` on a complete word. `RX_WAIT_SPACER`→`RX_WAIT_WORD` on all wires low. In transition mode the receiver stays in `RX_WAIT_WORD` and toggles acknowledge on each complete word.

Top module: `dual_rail_codec`

## Requirements
- R1: While reset is active and in the first cycle after it, every sender wire is low, `tx_ready` is high, and `rx_ack`, `rx_valid` and `rx_err` are low.
- R2: In return-to-zero mode, the cycle after a word is accepted (`tx_valid` and `tx_ready` high at a clock edge), bit b of the word appears on pair b: `tx_rail1[b]` high for a 1 and `tx_rail0[b]` high for a 0. No pair ever has both wires high, and the sender wires are either all low or a full codeword.
- R3: In return-to-zero mode the sender holds the codeword while `tx_ack` is low. One cycle after it samples `tx_ack` high, it drives all wires low. It holds that spacer and keeps `tx_ready` low while `tx_ack` stays high. One cycle after it samples `tx_ack` low, it raises `tx_ready` again.
- R4: In return-to-zero mode, one cycle after the receiver inputs first show a complete codeword (every pair exactly one wire high), `rx_ack` rises and `rx_valid` is high for exactly that one cycle. `rx_data` equals the `rx_rail1` value and holds until the next word.
- R5: In return-to-zero mode, `rx_ack` stays high while any receiver wire is high. It falls one cycle after all receiver wires are low.
- R6: A pair with both wires high (return-to-zero mode) or with both wires toggled since the last word (transition mode) raises `rx_err` the following cycle, and that sample is never taken as a word.
- R7: In transition mode, the cycle after a word is accepted, for each bit b the sender toggles `tx_rail1[b]` if the bit is 1 and `tx_rail0[b]` if it is 0. The other wire keeps its level. No spacer is sent. The sender stays busy with wires stable until `tx_ack` has toggled.
- R8: In transition mode, the receiver takes a word when every pair has exactly one wire changed since the last taken word. One cycle later `rx_ack` toggles, `rx_valid` pulses, and `rx_data` bit b is 1 where the one-wire toggled.
- R9: With the sender looped to the receiver through random per-wire skew and a random acknowledge delay, every word is delivered once, in order and unchanged, in both modes.
- R10: A partly arrived codeword (some pair still empty or unchanged) produces neither `rx_valid` nor a change of `rx_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Word offered to the sender |
| tx_data | input | N | Single-rail word to send |
| tx_ready | output | 1 | Sender takes a word at this edge when `tx_valid` is high |
| tx_rail0 | output | N | Sender zero-wires, one per bit |
| tx_rail1 | output | N | Sender one-wires, one per bit |
| tx_ack | input | 1 | Acknowledge returned from the far receiver |
| rx_rail0 | input | N | Receiver zero-wires |
| rx_rail1 | input | N | Receiver one-wires |
| rx_ack | output | 1 | Acknowledge to the far sender |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | N | Last received word |
| rx_err | output | 1 | Illegal pair code seen in the previous cycle |

## Verification
A sender stuck in the wrong state shows at the ports within one cycle of the acknowledge change that should have moved it. Either the spacer fails to appear, or the next codeword overwrites the current one, or `tx_ready` stays low forever. A receiver that judges completion wrongly shows at once as a `rx_valid` pulse on a partial word, or as an acknowledge that changes with no strobe. A wrong transition-mode memory of the last wire levels shows only on the following word, as a wrong `rx_data` or a false `rx_err`. The loopback run with skewed wires exposes that as an out-of-order or corrupted word. The small four-bit configuration lets the loopback sweep every word value in both modes.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_RTZ  = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_WAIT_WORD   = 1'b0,
        RX_WAIT_SPACER = 1'b1
    } rx_state_t;

    // pair code as {one_wire, zero_wire}
    typedef enum logic [1:0] {
        PAIR_EMPTY = 2'b00,
        PAIR_ZERO  = 2'b01,
        PAIR_ONE   = 2'b10,
        PAIR_BAD   = 2'b11
    } pair_t;

endpackage

// File: rtl/dr_pair_classify.sv
module dr_pair_classify #(
    parameter int N = 8
) (
    input  logic [N-1:0] lo,
    input  logic [N-1:0] hi,
    output logic         all_valid,
    output logic         all_empty,
    output logic         any_bad,
    output logic [N-1:0] value
);
    import dr_pkg::*;

    logic [N-1:0] is_valid;
    logic [N-1:0] is_empty;
    logic [N-1:0] is_bad;

    for (genvar i = 0; i < N; i++) begin : g_pair
        pair_t code;
        assign code        = pair_t'({hi[i], lo[i]});
        assign is_valid[i] = (code == PAIR_ZERO) || (code == PAIR_ONE);
        assign is_empty[i] = (code == PAIR_EMPTY);
        assign is_bad[i]   = (code == PAIR_BAD);
        assign value[i]    = (code == PAIR_ONE);
    end

    assign all_valid = &is_valid;
    assign all_empty = &is_empty;
    assign any_bad   = |is_bad;

endmodule

// File: rtl/dr_tx.sv
module dr_tx #(
    parameter int N         = 8,
    parameter bit TWO_PHASE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] in_data,
    output logic         in_ready,
    output logic [N-1:0] rail0,
    output logic [N-1:0] rail1,
    input  logic         ack
);
    import dr_pkg::*;

    tx_state_t    state_q, state_d;
    logic [N-1:0] word_q;
    logic [N-1:0] tog0_q, tog1_q;
    logic         phase_q;
    logic         accept;

    assign accept = (state_q == TX_IDLE) && in_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // word, toggle levels and expected acknowledge phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            tog0_q  <= '0;
            tog1_q  <= '0;
            phase_q <= 1'b0;
        end else if (accept) begin
            word_q  <= in_data;
            tog0_q  <= tog0_q ^ ~in_data;
            tog1_q  <= tog1_q ^ in_data;
            phase_q <= ~phase_q;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (in_valid) state_d = TX_SEND;
            TX_SEND: begin
                if (TWO_PHASE) begin
                    if (ack == phase_q) state_d = TX_IDLE;
                end else if (ack) begin
                    state_d = TX_RTZ;
                end
            end
            TX_RTZ:  if (!ack) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = (state_q == TX_IDLE);
        if (TWO_PHASE) begin
            rail0 = tog0_q;
            rail1 = tog1_q;
        end else if (state_q == TX_SEND) begin
            rail0 = ~word_q;
            rail1 = word_q;
        end else begin
            rail0 = '0;
            rail1 = '0;
        end
    end

endmodule

// File: rtl/dr_rx.sv
module dr_rx #(
    parameter int N         = 8,
    parameter bit TWO_PHASE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rail0,
    input  logic [N-1:0] rail1,
    output logic         ack,
    output logic         out_valid,
    output logic [N-1:0] out_data,
    output logic         err
);
    import dr_pkg::*;

    rx_state_t    state_q, state_d;
    logic [N-1:0] prev0_q, prev1_q;
    logic [N-1:0] cls_lo, cls_hi;
    logic [N-1:0] value;
    logic [N-1:0] data_q;
    logic         all_valid, all_empty, any_bad;
    logic         valid_q, err_q, tog_ack_q;
    logic         capture;

    // levels in return-to-zero mode, changes since last word in transition mode
    assign cls_lo = TWO_PHASE ? (rail0 ^ prev0_q) : rail0;
    assign cls_hi = TWO_PHASE ? (rail1 ^ prev1_q) : rail1;

    dr_pair_classify #(.N(N)) u_classify (
        .lo        (cls_lo),
        .hi        (cls_hi),
        .all_valid (all_valid),
        .all_empty (all_empty),
        .any_bad   (any_bad),
        .value     (value)
    );

    assign capture = (state_q == RX_WAIT_WORD) && all_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_WAIT_WORD;
        else        state_q <= state_d;
    end

    // captured word and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            valid_q   <= 1'b0;
            err_q     <= 1'b0;
            tog_ack_q <= 1'b0;
            prev0_q   <= '0;
            prev1_q   <= '0;
        end else begin
            valid_q   <= capture;
            err_q     <= any_bad;
            tog_ack_q <= tog_ack_q ^ capture;
            if (capture) begin
                data_q  <= value;
                prev0_q <= rail0;
                prev1_q <= rail1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT_WORD:   if (all_valid && !TWO_PHASE) state_d = RX_WAIT_SPACER;
            RX_WAIT_SPACER: if (all_empty) state_d = RX_WAIT_WORD;
            default:        state_d = RX_WAIT_WORD;
        endcase
    end

    // outputs
    always_comb begin
        ack       = TWO_PHASE ? tog_ack_q : (state_q == RX_WAIT_SPACER);
        out_valid = valid_q;
        out_data  = data_q;
        err       = err_q;
    end

endmodule

// File: rtl/dual_rail_codec.sv
module dual_rail_codec #(
    parameter int N         = 8,
    parameter bit TWO_PHASE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [N-1:0] tx_data,
    output logic         tx_ready,
    output logic [N-1:0] tx_rail0,
    output logic [N-1:0] tx_rail1,
    input  logic         tx_ack,
    input  logic [N-1:0] rx_rail0,
    input  logic [N-1:0] rx_rail1,
    output logic         rx_ack,
    output logic         rx_valid,
    output logic [N-1:0] rx_data,
    output logic         rx_err
);

    dr_tx #(.N(N), .TWO_PHASE(TWO_PHASE)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .rail0    (tx_rail0),
        .rail1    (tx_rail1),
        .ack      (tx_ack)
    );

    dr_rx #(.N(N), .TWO_PHASE(TWO_PHASE)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail0     (rx_rail0),
        .rail1     (rx_rail1),
        .ack       (rx_ack),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .err       (rx_err)
    );

endmodule

// File: rtl/dr_codec_checker.sv
module dr_codec_checker #(
    parameter int N         = 8,
    parameter bit TWO_PHASE = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_valid,
    input logic         tx_ready,
    input logic [N-1:0] tx_rail0,
    input logic [N-1:0] tx_rail1,
    input logic         tx_ack,
    input logic [N-1:0] rx_rail0,
    input logic [N-1:0] rx_rail1,
    input logic         rx_ack,
    input logic         rx_valid,
    input logic [N-1:0] rx_data,
    input logic         rx_err
);

    AST_RX_VALID_ON_ACK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_ack != $past(rx_ack))); // R4

    AST_RX_ACK_EDGE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack != $past(rx_ack)) && (TWO_PHASE || rx_ack) |-> rx_valid); // R8

    if (!TWO_PHASE) begin : g_rtz
        AST_TX_NO_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_rail0 & tx_rail1) == '0); // R2

        AST_TX_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            ((tx_rail0 | tx_rail1) == '0) || ((tx_rail0 | tx_rail1) == '1)); // R2

        AST_TX_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            ((tx_rail0 | tx_rail1) != '0) && !tx_ack |=> $stable(tx_rail0) && $stable(tx_rail1)); // R3

        AST_TX_HOLD_SPACER: assert property (@(posedge clk) disable iff (!rst_n)
            ((tx_rail0 | tx_rail1) == '0) && tx_ack |=> ((tx_rail0 | tx_rail1) == '0)); // R3

        AST_RX_DATA_FROM_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid |-> (rx_data == $past(rx_rail1))); // R4

        AST_RX_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid |=> !rx_valid); // R4

        AST_RX_ACK_FALLS_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rx_ack) |-> ($past(rx_rail0 | rx_rail1) == '0)); // R5

        AST_RX_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
            $past((rx_rail0 & rx_rail1) != '0) |-> rx_err && !rx_valid); // R6
    end else begin : g_trans
        AST_TX_ONE_TOGGLE_PER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid && tx_ready |=> ((tx_rail0 ^ $past(tx_rail0)) ^ (tx_rail1 ^ $past(tx_rail1))) == '1); // R7

        AST_TX_STABLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_ready |=> $stable(tx_rail0) && $stable(tx_rail1)); // R7
    end

endmodule

bind dual_rail_codec dr_codec_checker #(.N(N), .TWO_PHASE(TWO_PHASE)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_rail0 (tx_rail0),
    .tx_rail1 (tx_rail1),
    .tx_ack   (tx_ack),
    .rx_rail0 (rx_rail0),
    .rx_rail1 (rx_rail1),
    .rx_ack   (rx_ack),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_err   (rx_err)
);

// File: tb/test_dual_rail_codec.sv
module test_dual_rail_codec;

    localparam int W  = 4;
    localparam int NW = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lb = 1'b0;
    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    int mon_checks = 0, mon_fail = 0;
    int mon_a_n = 0, mon_b_n = 0;

    // instance A: return-to-zero, instance B: transition mode
    logic         a_tx_valid = 0, b_tx_valid = 0;
    logic [W-1:0] a_tx_data = '0, b_tx_data = '0;
    logic         a_tx_ready, b_tx_ready;
    logic [W-1:0] a_tx0, a_tx1, b_tx0, b_tx1;
    logic         a_ack_in, b_ack_in;
    logic [W-1:0] a_rx0, a_rx1, b_rx0, b_rx1;
    logic         a_rx_ack, b_rx_ack, a_rx_valid, b_rx_valid, a_rx_err, b_rx_err;
    logic [W-1:0] a_rx_data, b_rx_data;

    // directed drive
    logic         d_a_ack = 0, d_b_ack = 0;
    logic [W-1:0] d_a_r0 = '0, d_a_r1 = '0, d_b_r0 = '0, d_b_r1 = '0;
    // loopback channel with skew and delayed acknowledge
    logic         l_a_ack = 0, l_b_ack = 0;
    logic [W-1:0] l_a_r0 = '0, l_a_r1 = '0, l_b_r0 = '0, l_b_r1 = '0;

    assign a_ack_in = lb ? l_a_ack : d_a_ack;
    assign b_ack_in = lb ? l_b_ack : d_b_ack;
    assign a_rx0 = lb ? l_a_r0 : d_a_r0;
    assign a_rx1 = lb ? l_a_r1 : d_a_r1;
    assign b_rx0 = lb ? l_b_r0 : d_b_r0;
    assign b_rx1 = lb ? l_b_r1 : d_b_r1;

    dual_rail_codec #(.N(W), .TWO_PHASE(1'b0)) i_dual_rail_codec (
        .clk(clk), .rst_n(rst_n), .tx_valid(a_tx_valid), .tx_data(a_tx_data),
        .tx_ready(a_tx_ready), .tx_rail0(a_tx0), .tx_rail1(a_tx1), .tx_ack(a_ack_in),
        .rx_rail0(a_rx0), .rx_rail1(a_rx1), .rx_ack(a_rx_ack), .rx_valid(a_rx_valid),
        .rx_data(a_rx_data), .rx_err(a_rx_err));

    dual_rail_codec #(.N(W), .TWO_PHASE(1'b1)) i_dual_rail_codec_2p (
        .clk(clk), .rst_n(rst_n), .tx_valid(b_tx_valid), .tx_data(b_tx_data),
        .tx_ready(b_tx_ready), .tx_rail0(b_tx0), .tx_rail1(b_tx1), .tx_ack(b_ack_in),
        .rx_rail0(b_rx0), .rx_rail1(b_rx1), .rx_ack(b_rx_ack), .rx_valid(b_rx_valid),
        .rx_data(b_rx_data), .rx_err(b_rx_err));

    function automatic logic [W-1:0] word_of(input int k);
        return W'((k * 5 + 3) % 16);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // loopback wires: each wire follows the sender with random skew
    always @(negedge clk) begin
        if (!lb) begin
            l_a_r0 <= '0; l_a_r1 <= '0; l_b_r0 <= '0; l_b_r1 <= '0;
            l_a_ack <= 1'b0; l_b_ack <= 1'b0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if ($urandom_range(1) == 1) l_a_r0[i] <= a_tx0[i];
                if ($urandom_range(1) == 1) l_a_r1[i] <= a_tx1[i];
                if ($urandom_range(1) == 1) l_b_r0[i] <= b_tx0[i];
                if ($urandom_range(1) == 1) l_b_r1[i] <= b_tx1[i];
            end
            if ($urandom_range(2) == 0) l_a_ack <= a_rx_ack;
            if ($urandom_range(2) == 0) l_b_ack <= b_rx_ack;
        end
    end

    // loopback monitor: R9 order and value, R6 no false error
    always @(negedge clk) begin
        if (lb && rst_n) begin
            if (a_rx_valid) begin
                mon_checks++;
                if (a_rx_data !== word_of(mon_a_n)) begin
                    mon_fail++;
                    $display("FAIL R9 rtz word %0d actual=%0h expected=%0h", mon_a_n, a_rx_data, word_of(mon_a_n));
                end
                mon_a_n++;
            end
            if (b_rx_valid) begin
                mon_checks++;
                if (b_rx_data !== word_of(mon_b_n)) begin
                    mon_fail++;
                    $display("FAIL R9 trans word %0d actual=%0h expected=%0h", mon_b_n, b_rx_data, word_of(mon_b_n));
                end
                mon_b_n++;
            end
            if (a_rx_err || b_rx_err) begin
                mon_fail++;
                $display("FAIL R6 false error actual=%0h expected=0", {a_rx_err, b_rx_err});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fail + 1);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 tx rails in reset", {a_tx0, a_tx1, b_tx0, b_tx1}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 tx rails", {a_tx0, a_tx1, b_tx0, b_tx1}, 0);
        chk("R1 ready", {a_tx_ready, b_tx_ready}, 2'b11);
        chk("R1 rx flags", {a_rx_ack, a_rx_valid, a_rx_err, b_rx_ack, b_rx_valid, b_rx_err}, 0);

        // ---- return-to-zero sender ----
        a_tx_valid = 1; a_tx_data = 4'hA;
        tick(); a_tx_valid = 0;
        chk("R2 one-wires", a_tx1, 4'hA);
        chk("R2 zero-wires", a_tx0, 4'h5);
        chk("R3 busy", a_tx_ready, 0);
        repeat (3) tick();
        chk("R3 hold word", {a_tx1, a_tx0}, 8'hA5);
        d_a_ack = 1;
        tick();
        chk("R3 spacer", {a_tx1, a_tx0}, 0);
        a_tx_valid = 1; a_tx_data = 4'h3;
        tick();
        chk("R3 spacer held under ack", {a_tx1, a_tx0}, 0);
        chk("R3 not ready under ack", a_tx_ready, 0);
        d_a_ack = 0;
        tick();
        chk("R3 ready after ack low", a_tx_ready, 1);
        chk("R3 idle rails", {a_tx1, a_tx0}, 0);
        tick(); a_tx_valid = 0;
        chk("R2 second word", {a_tx1, a_tx0}, 8'h3C);
        d_a_ack = 1; tick(); d_a_ack = 0; tick();

        // ---- return-to-zero receiver ----
        d_a_r1 = 4'h1; d_a_r0 = 4'h0;
        tick();
        chk("R10 partial no valid", {a_rx_valid, a_rx_ack}, 0);
        d_a_r0 = 4'hE;
        tick();
        chk("R4 valid and ack", {a_rx_valid, a_rx_ack}, 2'b11);
        chk("R4 data", a_rx_data, 4'h1);
        tick();
        chk("R4 one strobe", {a_rx_valid, a_rx_ack}, 2'b01);
        d_a_r1 = 4'h0; d_a_r0 = 4'h6;
        tick();
        chk("R5 partial spacer keeps ack", a_rx_ack, 1);
        d_a_r0 = 4'h0;
        tick();
        chk("R5 ack falls on empty", a_rx_ack, 0);
        d_a_r1 = 4'h8; d_a_r0 = 4'h7;
        tick();
        chk("R4 second word", {a_rx_valid, a_rx_data}, 5'h18);
        d_a_r1 = 4'h0; d_a_r0 = 4'h0; tick(); tick();
        chk("R5 back to idle", a_rx_ack, 0);
        d_a_r1 = 4'h3; d_a_r0 = 4'hD;
        tick();
        chk("R6 rtz error", a_rx_err, 1);
        chk("R6 rtz no word", {a_rx_valid, a_rx_ack}, 0);
        d_a_r1 = 4'h0; d_a_r0 = 4'h0;
        tick();
        chk("R6 error clears", a_rx_err, 0);

        // ---- transition sender ----
        b_tx_valid = 1; b_tx_data = 4'h6;
        tick(); b_tx_valid = 0;
        chk("R7 first toggles", {b_tx1, b_tx0}, 8'h69);
        repeat (2) tick();
        chk("R7 hold until ack toggles", {b_tx_ready, b_tx1, b_tx0}, 9'h069);
        d_b_ack = 1;
        tick();
        chk("R7 ready after ack toggle", b_tx_ready, 1);
        chk("R7 no spacer", {b_tx1, b_tx0}, 8'h69);
        b_tx_valid = 1; b_tx_data = 4'h5;
        tick(); b_tx_valid = 0;
        chk("R7 second toggles", {b_tx1, b_tx0}, 8'h33);
        d_b_ack = 0;
        tick();
        chk("R7 ready again", b_tx_ready, 1);

        // ---- transition receiver ----
        d_b_r1 = 4'h1; d_b_r0 = 4'h0;
        tick();
        chk("R10 transition partial", {b_rx_valid, b_rx_ack}, 0);
        d_b_r0 = 4'hE;
        tick();
        chk("R8 first word", {b_rx_valid, b_rx_ack, b_rx_data}, 6'h31);
        tick();
        chk("R8 strobe ends, ack held", {b_rx_valid, b_rx_ack}, 2'b01);
        d_b_r1 = 4'h9; d_b_r0 = 4'h9;
        tick();
        chk("R8 second word", {b_rx_valid, b_rx_ack, b_rx_data}, 6'h28);
        d_b_r1 = 4'h8; d_b_r0 = 4'h8;
        tick();
        chk("R6 transition error", {b_rx_err, b_rx_valid}, 2'b10);

        // ---- loopback sweep, R9 ----
        rst_n = 0;
        d_a_r0 = '0; d_a_r1 = '0; d_b_r0 = '0; d_b_r1 = '0; d_a_ack = 0; d_b_ack = 0;
        repeat (2) tick();
        rst_n = 1; lb = 1;
        fork
            begin
                for (int k = 0; k < NW; k++) begin
                    do tick(); while (!a_tx_ready);
                    a_tx_valid = 1; a_tx_data = word_of(k);
                    tick(); a_tx_valid = 0;
                end
            end
            begin
                for (int k = 0; k < NW; k++) begin
                    do tick(); while (!b_tx_ready);
                    b_tx_valid = 1; b_tx_data = word_of(k);
                    tick(); b_tx_valid = 0;
                end
            end
        join
        wait (mon_a_n == NW && mon_b_n == NW);
        repeat (4) tick();
        chk("R9 rtz word count", mon_a_n, NW);
        chk("R9 transition word count", mon_b_n, NW);

        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
        $finish;
    end

endmodule